// File: doc/BRIEF.md
# Paired-Compare PWM with Fractional Edge Dithering

This block generates one PWM output from two compare values against a shared up-counter. The counter steps from a programmable start value up to a programmable modulus and then restarts. The output goes high when the counter reaches the first compare value and goes low when it reaches the second. A waveform whose pulse edges sit between two counter ticks can be approximated by moving either edge one count later in some periods.

Each edge has its own 5-bit fractional accumulator. At every counter restart, the accumulator adds its fractional input. The sum wraps modulo 32. A carry out of that addition delays the matching edge by exactly one count for the whole next period. Over 32 periods, an edge is therefore late in as many periods as its fractional value. A fractional value of zero leaves the edge fixed.

Top module: `pwm_pair_dither`

## Requirements
- R1: Reset loads the counter with `start_cnt`. After reset, the counter increments by one per clock while it is below `modulus`, and a cycle in which it equals `modulus` is followed by `start_cnt`.
- R2: `period_start` is high for exactly the one cycle after the counter showed `modulus`, which is the first count of each new period. It is low otherwise and during reset.
- R3: At every restart, each accumulator takes (accumulator + fraction) mod 32, starting from 0 after reset. The carry of that sum (the sum is 32 or more) is held unchanged through the whole following period. In the k-th period after reset (k ≥ 2), an edge is delayed if floor((k-1)·f/32) > floor((k-2)·f/32), where f is the edge's fractional value.
- R4: In a period without a carry for the set edge, `pwm_out` becomes 1 in the cycle after the counter equals `set_cmp`.
- R5: In a period with a carry for the set edge, `pwm_out` becomes 1 in the cycle after the counter equals `set_cmp` + 1.
- R6: The clear edge follows the same rule with `clr_cmp` and its own carry. `pwm_out` becomes 0 in the cycle after the counter equals `clr_cmp`, or `clr_cmp` + 1 in a carry period.
- R7: A fractional value of 0 never delays its edge.
- R8: The two accumulators are independent, so the set edge, the clear edge or both may be delayed in a given period.
- R9: During and right after reset, `pwm_out` and `period_start` are 0 and both accumulators are 0.
- R10: If the set and clear points coincide on the same count, the clear wins and `pwm_out` is driven to 0.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_cnt | input | CNT_W | Counter value at the start of each period |
| modulus | input | CNT_W | Last counter value of each period |
| set_cmp | input | CNT_W | Compare value for the rising edge |
| clr_cmp | input | CNT_W | Compare value for the falling edge |
| set_frac | input | 5 | Fractional value for the rising edge |
| clr_frac | input | 5 | Fractional value for the falling edge |
| pwm_out | output | 1 | Combined PWM output (registered) |
| cnt_out | output | CNT_W | Current counter value |
| period_start | output | 1 | One-cycle strobe on the first count of each period |

## Verification
The assertions assume the following about the inputs:
- `start_cnt` is not above `modulus`.
- The counter starts at or below `modulus`.
- The count, compare and modulus inputs stay constant while reset is low. The step and wrap properties only describe a counter whose limits do not move under it.

The stimulus changes configuration only while reset is held. It keeps both compare points strictly between the start value and `modulus` − 1, so every edge, delayed or not, falls inside its own period.

// File: rtl/pwm_dither_pkg.sv
package pwm_dither_pkg;
  localparam int FRAC_W   = 5;
  localparam int N_EDGES  = 2;
  localparam int EDGE_SET = 0;
  localparam int EDGE_CLR = 1;
endpackage

// File: rtl/pwm_frac_accum.sv
module pwm_frac_accum #(
  parameter int FRAC_W = pwm_dither_pkg::FRAC_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] acc_q;
  logic [SUM_W-1:0]  sum;

  assign sum = {1'b0, acc_q} + {1'b0, frac};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      carry <= 1'b0;
    end else if (restart) begin
      acc_q <= sum[FRAC_W-1:0];
      carry <= sum[FRAC_W];
    end
  end
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [CNT_W-1:0] modulus,
  output logic [CNT_W-1:0] cnt_q,
  output logic             restart,
  output logic             period_start
);
  assign restart = (cnt_q >= modulus);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= start_cnt;
      period_start <= 1'b0;
    end else begin
      period_start <= restart;
      cnt_q        <= restart ? start_cnt : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_edge_out.sv
module pwm_edge_out #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] set_cmp,
  input  logic [CNT_W-1:0] clr_cmp,
  input  logic             set_late,
  input  logic             clr_late,
  output logic             pwm_q
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cnt_ext, set_pt, clr_pt;
  logic             hit_set, hit_clr;

  assign cnt_ext = {1'b0, cnt};
  assign set_pt  = {1'b0, set_cmp} + {{CNT_W{1'b0}}, set_late};
  assign clr_pt  = {1'b0, clr_cmp} + {{CNT_W{1'b0}}, clr_late};
  assign hit_set = (cnt_ext == set_pt);
  assign hit_clr = (cnt_ext == clr_pt);

  always_ff @(posedge clk) begin
    if (rst)          pwm_q <= 1'b0;
    else if (hit_clr) pwm_q <= 1'b0;
    else if (hit_set) pwm_q <= 1'b1;
  end
endmodule

// File: rtl/pwm_pair_dither.sv
module pwm_pair_dither
  import pwm_dither_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] start_cnt,
  input  logic [CNT_W-1:0] modulus,
  input  logic [CNT_W-1:0] set_cmp,
  input  logic [CNT_W-1:0] clr_cmp,
  input  logic [4:0]       set_frac,
  input  logic [4:0]       clr_frac,
  output logic             pwm_out,
  output logic [CNT_W-1:0] cnt_out,
  output logic             period_start
);
  logic                      restart;
  logic [N_EDGES-1:0]        edge_late;
  logic [N_EDGES-1:0][FRAC_W-1:0] frac_vec;

  assign frac_vec[EDGE_SET] = set_frac;
  assign frac_vec[EDGE_CLR] = clr_frac;

  pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .start_cnt    (start_cnt),
    .modulus      (modulus),
    .cnt_q        (cnt_out),
    .restart      (restart),
    .period_start (period_start)
  );

  for (genvar e = 0; e < N_EDGES; e++) begin : g_acc
    pwm_frac_accum #(.FRAC_W(FRAC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .restart (restart),
      .frac    (frac_vec[e]),
      .carry   (edge_late[e])
    );
  end

  pwm_edge_out #(.CNT_W(CNT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .cnt      (cnt_out),
    .set_cmp  (set_cmp),
    .clr_cmp  (clr_cmp),
    .set_late (edge_late[EDGE_SET]),
    .clr_late (edge_late[EDGE_CLR]),
    .pwm_q    (pwm_out)
  );
endmodule

// File: rtl/pwm_pair_dither_chk.sv
module pwm_pair_dither_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] start_cnt,
  input logic [CNT_W-1:0] modulus,
  input logic [CNT_W-1:0] set_cmp,
  input logic [CNT_W-1:0] clr_cmp,
  input logic [CNT_W-1:0] cnt_out,
  input logic             pwm_out,
  input logic             period_start,
  input logic             late_set,
  input logic             late_clr
);
  logic [CNT_W:0] c_ext, s_pt, k_pt;
  logic           at_set, at_clr;

  always_comb begin
    c_ext  = {1'b0, cnt_out};
    s_pt   = {1'b0, set_cmp} + {{CNT_W{1'b0}}, late_set};
    k_pt   = {1'b0, clr_cmp} + {{CNT_W{1'b0}}, late_clr};
    at_set = (c_ext == s_pt);
    at_clr = (c_ext == k_pt);
  end

  a_r1_step: assert property (@(posedge clk) disable iff (rst)
    (cnt_out < modulus) |=> (cnt_out == $past(cnt_out) + 1'b1));

  a_r1_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_out == modulus) |=> (cnt_out == $past(start_cnt)));

  a_r2_strobe_on: assert property (@(posedge clk) disable iff (rst)
    (cnt_out == modulus) |=> period_start);

  a_r2_strobe_off: assert property (@(posedge clk) disable iff (rst)
    (cnt_out != modulus) |=> !period_start);

  a_r3_carry_held: assert property (@(posedge clk) disable iff (rst)
    (cnt_out != modulus) |=> ($stable(late_set) && $stable(late_clr)));

  a_r5_rise: assert property (@(posedge clk) disable iff (rst)
    (at_set && !at_clr) |=> pwm_out);

  a_r6_fall: assert property (@(posedge clk) disable iff (rst)
    at_clr |=> !pwm_out);

  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!at_set && !at_clr) |=> $stable(pwm_out));
endmodule

bind pwm_pair_dither pwm_pair_dither_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .start_cnt    (start_cnt),
  .modulus      (modulus),
  .set_cmp      (set_cmp),
  .clr_cmp      (clr_cmp),
  .cnt_out      (cnt_out),
  .pwm_out      (pwm_out),
  .period_start (period_start),
  .late_set     (edge_late[0]),
  .late_clr     (edge_late[1])
);

// File: tb/pwm_pair_dither_bench.sv
`timescale 1ns/1ps
module pwm_pair_dither_bench;
  localparam int CNT_W = 16;
  localparam int P     = 65;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [CNT_W-1:0] start_cnt = 16'd2, modulus = 16'd13;
  logic [CNT_W-1:0] set_cmp = 16'd4, clr_cmp = 16'd9;
  logic [4:0]       set_frac = '0, clr_frac = '0;
  logic             pwm_out, period_start;
  logic [CNT_W-1:0] cnt_out;

  int checks = 0, errors = 0;
  bit started = 0;

  // reference model state
  int m_cnt, m_acc_s, m_acc_c, m_pwm, m_pst;
  bit m_late_s, m_late_c;
  // edge statistics
  int rises, falls, late_rises, late_falls, prev_cnt, prev_pwm;

  always #5 clk = ~clk;

  pwm_pair_dither #(.CNT_W(CNT_W)) u_pwm_pair_dither (
    .clk(clk), .rst(rst), .start_cnt(start_cnt), .modulus(modulus),
    .set_cmp(set_cmp), .clr_cmp(clr_cmp), .set_frac(set_frac),
    .clr_frac(clr_frac), .pwm_out(pwm_out), .cnt_out(cnt_out),
    .period_start(period_start));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      m_cnt = int'(start_cnt); m_acc_s = 0; m_acc_c = 0;
      m_late_s = 0; m_late_c = 0; m_pwm = 0; m_pst = 0;
    end else begin
      int rise_at, fall_at;
      rise_at = int'(set_cmp) + (m_late_s ? 1 : 0);
      fall_at = int'(clr_cmp) + (m_late_c ? 1 : 0);
      if (m_cnt == fall_at)      m_pwm = 0;
      else if (m_cnt == rise_at) m_pwm = 1;
      m_pst = (m_cnt == int'(modulus)) ? 1 : 0;
      if (m_cnt == int'(modulus)) begin
        m_acc_s = m_acc_s + int'(set_frac);
        m_late_s = (m_acc_s >= 32);
        m_acc_s = m_acc_s % 32;
        m_acc_c = m_acc_c + int'(clr_frac);
        m_late_c = (m_acc_c >= 32);
        m_acc_c = m_acc_c % 32;
        m_cnt = int'(start_cnt);
      end else begin
        m_cnt = m_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check(int'(cnt_out) == m_cnt, "R1 counter", int'(cnt_out), m_cnt);
      check(int'(period_start) == m_pst, "R2 strobe", int'(period_start), m_pst);
      check(int'(pwm_out) == m_pwm, "R4 R5 R6 R8 R10 output", int'(pwm_out), m_pwm);
    end
    if (rst) begin
      rises = 0; falls = 0; late_rises = 0; late_falls = 0;
    end else begin
      if (pwm_out && prev_pwm == 0) begin
        rises++;
        if (prev_cnt == int'(set_cmp) + 1) late_rises++;
      end
      if (!pwm_out && prev_pwm == 1) begin
        falls++;
        if (prev_cnt == int'(clr_cmp) + 1) late_falls++;
      end
    end
    prev_cnt = int'(cnt_out);
    prev_pwm = int'(pwm_out);
  end

  task automatic run_cfg(input int s, input int c, input int fs, input int fc, input bit count_edges);
    int len;
    @(negedge clk);
    rst = 1'b1;
    set_cmp = CNT_W'(s); clr_cmp = CNT_W'(c);
    set_frac = 5'(fs); clr_frac = 5'(fc);
    repeat (3) @(negedge clk);
    // R9: reset state
    check(pwm_out == 1'b0, "R9 reset pwm", int'(pwm_out), 0);
    check(period_start == 1'b0, "R9 reset strobe", int'(period_start), 0);
    check(cnt_out == start_cnt, "R1 reset count", int'(cnt_out), int'(start_cnt));
    rst = 1'b0;
    len = int'(modulus) - int'(start_cnt) + 1;
    repeat (P * len) @(negedge clk);
    if (count_edges) begin
      check(rises == P, "R4 rises per period", rises, P);
      check(falls == P, "R6 falls per period", falls, P);
      check(late_rises == ((P - 1) * fs) / 32, "R3 R5 late set edges", late_rises, ((P - 1) * fs) / 32);
      check(late_falls == ((P - 1) * fc) / 32, "R3 R6 R8 late clear edges", late_falls, ((P - 1) * fc) / 32);
      if (fs == 0) check(late_rises == 0, "R7 zero fraction set", late_rises, 0);
      if (fc == 0) check(late_falls == 0, "R7 zero fraction clear", late_falls, 0);
    end else begin
      check(rises == 0, "R10 coincident edges", rises, 0);
    end
  endtask

  initial begin
    run_cfg(4, 9, 0, 0, 1);
    run_cfg(4, 9, 3, 0, 1);
    run_cfg(4, 9, 0, 7, 1);
    run_cfg(4, 9, 16, 31, 1);
    run_cfg(5, 8, 5, 11, 1);
    run_cfg(6, 6, 0, 0, 0);
    run_cfg(6, 6, 9, 9, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule